// File: doc/BRIEF.md
# Edge-Triggered Pin Debouncer

This block filters one noisy input pin that is watched by an edge detector. It does nothing until a trigger pulse from that detector arrives. It then looks at the pin once per sample tick and compares it with a stored filtered level. A new level is taken only after the pin has held it for a set number of consecutive ticks. The count for a rising change and the count for a falling change are separate parameters.

When a change is taken, checking stops, the filtered level updates and an event pulse may be raised. The block also reverses the edge direction it asks the detector to watch, so the next edge in the other direction starts a new check. A load pulse sets the filtered level from the pin as it is now.

The reported level can be inverted for pins that are active low. A dual-edge mode raises the event on every accepted change.

Top module: `edge_debouncer`

## Requirements
- R1: A `load` pulse copies the synchronized pin into the filtered state and sets `arm_rise` to the inverse of that level (1 = the detector should watch for a rising edge). `load` has priority over every other input and ends any check in progress.
- R2: While no check is running, ticks and pin changes leave `dbn_level` unchanged and raise no event.
- R3: A `trig` pulse while idle starts a check. On each tick during a check where the pin equals the filtered state, the counter reloads and the check continues.
- R4: During a check, a pin level that differs from the state is taken on the RISE_CNT-th consecutive differing tick for a low-to-high change, or the FALL_CNT-th for a high-to-low change. No earlier tick takes it.
- R5: A tick during a check where the pin matches the state again reloads the counter. The full count then has to restart.
- R6: When a change is taken, the check stops. `arm_rise` inverts, and later pin changes have no effect until the next `trig`.
- R7: When a change is taken, `evt` is raised if dual-edge mode is on, if the new level is high with `active_low`=0, or if the new level is low with `active_low`=1. In every other case `evt` stays low.
- R8: `evt` is high for exactly one clock cycle per accepted change.
- R9: A `trig` that arrives during a check is ignored. It neither restarts nor extends the count.
- R10: `dbn_level` equals the filtered state, XOR-ed with `active_low`.
- R11: After reset the filtered state is 0, `arm_rise` is 1, `evt` is 0 and no check is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_in | input | 1 | Raw pin level, asynchronous |
| tick | input | 1 | Sample-period strobe, one cycle wide |
| trig | input | 1 | Edge-detected pulse that starts a check |
| load | input | 1 | Sets the filtered state from the current pin level |
| active_low | input | 1 | Inverts the reported level and the event polarity |
| dual_edge | input | 1 | Raise the event on every accepted change |
| dbn_level | output | 1 | Filtered level, after the active-low mapping |
| evt | output | 1 | One-cycle event pulse on an accepted change |
| arm_rise | output | 1 | 1 = the detector should watch for a rising edge, 0 = a falling edge |

## Verification
The bench sweeps every combination of `active_low`, `dual_edge` and change direction, using different rise and fall counts. A design that swapped the two counts, or took a change one tick early or late, would show the new level on the wrong tick. A design with the event qualification wrong would pulse in the wrong cases, and a stretched pulse would show up in the cycle after the change. A bounce in the middle of a count checks that the counter reloads; a design that only paused the count would take the change too early. A second `trig` during a check would delay acceptance if it reloaded the counter. Pin changes after acceptance would move the level if the check did not stop.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

   typedef enum logic {PH_IDLE = 1'b0, PH_CHECK = 1'b1} phase_e;

   // Event qualification for a newly accepted level.
   function automatic logic evt_qualify(input logic new_lvl,
                                        input logic act_low,
                                        input logic dual);
      return dual | (new_lvl ^ act_low);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (STAGES == 1) sh_q <= d;
            else sh_q <= {sh_q[STAGES-2:0], d};
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dbn_count.sv
module dbn_count #(
   parameter int RISE_CNT = 2,
   parameter int FALL_CNT = 2,
   parameter int CNT_W    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic reload_hi,
   input  logic dec,
   output logic at_last
);
   localparam logic [CNT_W-1:0] RISE_V = CNT_W'(RISE_CNT);
   localparam logic [CNT_W-1:0] FALL_V = CNT_W'(FALL_CNT);
   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= RISE_V;
      else if (reload) cnt_q <= reload_hi ? FALL_V : RISE_V;
      else if (dec)    cnt_q <= cnt_q - ONE_V;
   end

   assign at_last = (cnt_q == ONE_V);
endmodule

// File: rtl/edge_debouncer.sv
module edge_debouncer #(
   parameter int RISE_CNT    = 2,
   parameter int FALL_CNT    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   input  logic tick,
   input  logic trig,
   input  logic load,
   input  logic active_low,
   input  logic dual_edge,
   output logic dbn_level,
   output logic evt,
   output logic arm_rise
);
   import dbn_pkg::*;

   localparam int MAX_CNT = max2(RISE_CNT, FALL_CNT);
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (RISE_CNT < 1) begin : g_bad_rise
         $error("RISE_CNT must be at least 1");
      end
      if (FALL_CNT < 1) begin : g_bad_fall
         $error("FALL_CNT must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic   raw_s;
   logic   state_q;
   logic   arm_q;
   logic   evt_q;
   phase_e busy_q;
   logic   differs;
   logic   sample;
   logic   cnt_last;
   logic   accept;
   logic   cnt_reload;
   logic   cnt_dec;

   dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (raw_s)
   );

   assign differs    = raw_s ^ state_q;
   assign sample     = (busy_q == PH_CHECK) & tick & ~load;
   assign accept     = sample & differs & cnt_last;
   // The reload target is always the level the pin shows now: on load it is
   // the new state, on a match it equals the state, on accept it is the new state.
   assign cnt_reload = load | (sample & (~differs | cnt_last));
   assign cnt_dec    = sample & differs & ~cnt_last;

   dbn_count #(
      .RISE_CNT (RISE_CNT),
      .FALL_CNT (FALL_CNT),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (cnt_reload),
      .reload_hi (raw_s),
      .dec       (cnt_dec),
      .at_last   (cnt_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         arm_q   <= 1'b1;
         busy_q  <= PH_IDLE;
         evt_q   <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (load) begin
            state_q <= raw_s;
            arm_q   <= ~raw_s;
            busy_q  <= PH_IDLE;
         end else if (busy_q == PH_IDLE) begin
            if (trig) busy_q <= PH_CHECK;
         end else if (accept) begin
            state_q <= raw_s;
            arm_q   <= ~arm_q;
            busy_q  <= PH_IDLE;
            evt_q   <= evt_qualify(raw_s, active_low, dual_edge);
         end
      end
   end

   assign dbn_level = state_q ^ active_low;
   assign evt       = evt_q;
   assign arm_rise  = arm_q;
endmodule

// File: rtl/dbn_checker.sv
module dbn_checker (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic load,
   input logic evt,
   input logic arm_rise,
   input logic busy,
   input logic state
);
   // R8: the event lasts a single cycle
   a_r8_evt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

   // R6: the arming direction always points away from the filtered state
   a_r6_arm_opposite: assert property (@(posedge clk) disable iff (!rst_n)
      arm_rise == !state);

   // R9: a check only ends on a tick or a load
   a_r9_check_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !load) |=> busy);

   // R2: while idle the state moves only through load
   a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> $stable(state));

   // R7: an event comes only at the end of a check
   a_r7_evt_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> ($past(busy) && !busy && $past(tick)));
endmodule

bind edge_debouncer dbn_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .load     (load),
   .evt      (evt),
   .arm_rise (arm_rise),
   .busy     (busy_q),
   .state    (state_q)
);

// File: tb/sim_edge_debouncer.sv
module sim_edge_debouncer;
   localparam int RISE = 2;
   localparam int FALL = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw_in = 1'b0, tick = 1'b0, trig = 1'b0, load = 1'b0;
   logic active_low = 1'b0, dual_edge = 1'b0;
   logic dbn_level, evt, arm_rise;
   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   edge_debouncer #(.RISE_CNT(RISE), .FALL_CNT(FALL), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .tick(tick), .trig(trig),
      .load(load), .active_low(active_low), .dual_edge(dual_edge),
      .dbn_level(dbn_level), .evt(evt), .arm_rise(arm_rise)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic set_raw(input logic v);
      raw_in = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_load();
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic do_trig();
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic do_tick(output logic ev);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      ev = evt;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic ev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 level after reset", dbn_level, 1'b0);
      chk("R11 evt after reset", evt, 1'b0);
      chk("R11 arm after reset", arm_rise, 1'b1);

      // R2: idle ignores pin and ticks
      set_raw(1'b1);
      for (int i = 0; i < 4; i++) begin
         do_tick(ev);
         chk("R2 idle level", dbn_level, 1'b0);
         chk("R2 idle evt", ev, 1'b0);
      end

      // Sweep of polarity, mode and direction
      for (int al = 0; al < 2; al++) begin
         for (int de = 0; de < 2; de++) begin
            for (int st = 0; st < 2; st++) begin
               logic start, nw, exp_ev;
               int n;
               start = st[0];
               nw = ~start;
               n = nw ? RISE : FALL;
               exp_ev = (de != 0) | (nw ^ al[0]);
               active_low = al[0];
               dual_edge = de[0];
               set_raw(start);
               do_load();
               chk("R1 load level", dbn_level, start ^ al[0]);
               chk("R1 load arm", arm_rise, ~start);
               chk("R10 load mapping", dbn_level, start ^ al[0]);
               set_raw(nw);
               do_trig();
               for (int k = 1; k < n; k++) begin
                  do_tick(ev);
                  chk("R4 early tick level", dbn_level, start ^ al[0]);
                  chk("R4 early tick evt", ev, 1'b0);
               end
               do_tick(ev);
               chk("R4 accept level", dbn_level, nw ^ al[0]);
               chk("R10 accept mapping", dbn_level, nw ^ al[0]);
               chk("R7 event qualify", ev, exp_ev);
               chk("R8 event ended", evt, 1'b0);
               chk("R6 arm flipped", arm_rise, start);
               set_raw(start);
               for (int k = 0; k < 3; k++) begin
                  do_tick(ev);
                  chk("R6 stopped level", dbn_level, nw ^ al[0]);
                  chk("R6 stopped evt", ev, 1'b0);
               end
            end
         end
      end
      active_low = 1'b0;
      dual_edge = 1'b0;

      // R3: matching samples keep the check running
      set_raw(1'b0);
      do_load();
      do_trig();
      for (int k = 0; k < 3; k++) begin
         do_tick(ev);
         chk("R3 match level", dbn_level, 1'b0);
      end
      set_raw(1'b1);
      do_tick(ev);
      chk("R3 still counting", dbn_level, 1'b0);
      do_tick(ev);
      chk("R3 accept after matches", dbn_level, 1'b1);
      chk("R3 accept evt", ev, 1'b1);

      // R5: a bounce reloads the count (falling, FALL=3)
      set_raw(1'b0);
      do_trig();
      do_tick(ev);
      do_tick(ev);
      set_raw(1'b1);
      do_tick(ev);
      chk("R5 bounce level", dbn_level, 1'b1);
      set_raw(1'b0);
      do_tick(ev);
      chk("R5 recount 1", dbn_level, 1'b1);
      do_tick(ev);
      chk("R5 recount 2", dbn_level, 1'b1);
      do_tick(ev);
      chk("R5 recount accept", dbn_level, 1'b0);
      chk("R5 evt low level", ev, 1'b0);

      // R9: second trigger during a check is ignored
      set_raw(1'b1);
      do_trig();
      do_tick(ev);
      chk("R9 first tick", dbn_level, 1'b0);
      do_trig();
      do_tick(ev);
      chk("R9 accept not delayed", dbn_level, 1'b1);
      chk("R9 evt", ev, 1'b1);

      // R1: load during a check ends it
      set_raw(1'b0);
      do_trig();
      do_tick(ev);
      set_raw(1'b1);
      do_load();
      chk("R1 load mid check", dbn_level, 1'b1);
      set_raw(1'b0);
      for (int k = 0; k < 4; k++) do_tick(ev);
      chk("R1 check ended by load", dbn_level, 1'b1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule